// File: doc/BRIEF.md
# MSI and Legacy Interrupt Requester

This block is the interrupt source on the application side of a PCIe endpoint. User logic signals interrupt events as one-cycle pulses on a vector-indexed event bus. Each pulse sets a bit in a pending register. The block then raises each pending event with the transaction core in one of two ways, chosen by whether message-signalled interrupts are enabled.

With MSI enabled, the block drives a sticky request carrying a traffic class and a vector number. It holds that request until the core returns an acknowledge. The vector number is folded into the range the host actually allocated. The host writes this allocation as a power-of-two count in the 3-bit multiple-message-enable field, and it may be smaller than the count the function asked for. With MSI disabled, the block falls back to a legacy level interrupt, and both its rising and its falling transition are confirmed by a separate acknowledge from the core.

The mode is chosen only between sequences, so a request or level transition that has started always finishes under the rules it began with.

Top module: `msi_irq_requester`

## Requirements
- R1: After reset, msiReq and intSts are low, msiNum is 0 and no event is pending, so neither output rises until an event arrives.
- R2: A pulse on evtIn bit v is latched at that clock edge. With msiEn high and no sequence in progress, msiReq rises after the following edge, with msiTc equal to cfgTc and msiNum derived from v.
- R3: While msiAck is low, msiReq stays high and msiTc and msiNum hold their values. msiReq falls at the edge that samples msiAck high. A msiAck that arrives while no request is up has no effect.
- R4: cfgMme = k allocates 2^k vectors. msiNum carries only the low k bits of v, and the upper bits are forced to 0. Values 6 and 7 are treated as 5, so the full 5-bit vector passes.
- R5: Several pending events are issued one request at a time, lowest vector index first. msiReq is low for exactly one cycle between successive requests.
- R6: An event that arrives while a request is outstanding stays pending and is issued after the current acknowledge, ordered with the others by R5.
- R7: With msiEn low, a pending event raises intSts after the following edge. intSts stays high until intAck is seen. That acknowledge consumes all pending events, and events arriving while the level is held are consumed as well. intSts falls in the first cycle in which nothing is pending.
- R8: After intSts falls, no new raise happens until intAck confirms the deassertion. Events arriving in that window stay pending and raise intSts after the edge that follows the confirming edge.
- R9: msiReq and intSts are never high together. A change of msiEn during a sequence does not affect that sequence.
- R10: Repeated pulses on a vector that is already pending merge into a single request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 32 | Interrupt event pulses, bit index is the requested vector |
| msiEn | input | 1 | MSI enable from configuration space |
| cfgMme | input | 3 | Host-allocated vector count, encoded as log2 |
| cfgTc | input | 3 | Traffic class to attach to MSI requests |
| msiReq | output | 1 | Sticky MSI request |
| msiTc | output | 3 | Traffic class of the current request |
| msiNum | output | 5 | Vector number of the current request, folded to the allocation |
| msiAck | input | 1 | Acknowledge pulse for msiReq |
| intSts | output | 1 | Legacy interrupt level |
| intAck | input | 1 | Acknowledge pulse for each intSts transition |

## Verification
A table sweeps single events across vector indices, allocation codes 0 to 7 and several traffic classes. Comparing msiNum against the masked vector tells correct folding apart from truncating at the wrong bit, and it shows that the reserved codes are clamped to 5. Bursts of simultaneous events, and events arriving under an outstanding request, separate lowest-first issue from arrival-order issue and show the one-cycle gap between requests. Legacy sequences with and without events during the held and falling phases tell absorption apart from premature release. They also show whether the falling transition really waits for its acknowledge.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MSI_WAIT,
    ST_LEG_UP,
    ST_LEG_HOLD,
    ST_LEG_DOWN
  } irqState_t;

  typedef struct packed {
    logic issueMsi;   // launch request for lowest pending vector
    logic clrAll;     // consume every pending event (legacy)
  } dpCtl_t;
endpackage

// File: rtl/irq_req_datapath.sv
module irq_req_datapath
  import irq_req_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int TC_W    = 3,
  parameter int MME_W   = 3,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] evtIn,
  input  dpCtl_t             ctl,
  input  logic [TC_W-1:0]    cfgTc,
  input  logic [MME_W-1:0]   cfgMme,
  output logic               anyPend,
  output logic [VEC_W-1:0]   msiNum,
  output logic [TC_W-1:0]    msiTc
);
  logic [NUM_VEC-1:0] pend;
  logic [NUM_VEC-1:0] lowOh;
  logic [NUM_VEC-1:0] clrMask;
  logic [VEC_W-1:0]   lowIdx;
  logic [MME_W-1:0]   mmeClamp;
  logic [VEC_W:0]     maskWide;
  logic [VEC_W-1:0]   vecMask;

  assign anyPend = |pend;
  assign lowOh   = pend & (~pend + NUM_VEC'(1));

  always_comb begin
    lowIdx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pend[i]) lowIdx = VEC_W'(i);
    end
  end

  assign mmeClamp = (int'(cfgMme) > VEC_W) ? MME_W'(VEC_W) : cfgMme;
  assign maskWide = (VEC_W + 1)'(1) << mmeClamp;
  assign vecMask  = VEC_W'(maskWide - (VEC_W + 1)'(1));

  always_comb begin
    clrMask = '0;
    if (ctl.clrAll)        clrMask = '1;
    else if (ctl.issueMsi) clrMask = lowOh;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend   <= '0;
      msiNum <= '0;
      msiTc  <= '0;
    end else begin
      pend <= (pend & ~clrMask) | evtIn;
      if (ctl.issueMsi) begin
        msiNum <= lowIdx & vecMask;
        msiTc  <= cfgTc;
      end
    end
  end

  AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issueMsi |=> ((msiNum & ~$past(vecMask)) == '0)); // R4

  AST_ISSUE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issueMsi |-> $onehot(lowOh)); // R5
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
  import irq_req_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   msiEn,
  input  logic   anyPend,
  input  logic   msiAck,
  input  logic   intAck,
  output dpCtl_t ctl,
  output logic   msiReq,
  output logic   intSts
);
  irqState_t state, stateNxt;

  always_comb begin
    stateNxt     = state;
    ctl.issueMsi = 1'b0;
    ctl.clrAll   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (anyPend) begin
          if (msiEn) begin
            stateNxt     = ST_MSI_WAIT;
            ctl.issueMsi = 1'b1;
          end else begin
            stateNxt = ST_LEG_UP;
          end
        end
      end
      ST_MSI_WAIT: if (msiAck) stateNxt = ST_IDLE;
      ST_LEG_UP: begin
        if (intAck) begin
          stateNxt   = ST_LEG_HOLD;
          ctl.clrAll = 1'b1;
        end
      end
      ST_LEG_HOLD: begin
        if (anyPend) ctl.clrAll = 1'b1;
        else         stateNxt   = ST_LEG_DOWN;
      end
      ST_LEG_DOWN: if (intAck) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign msiReq = (state == ST_MSI_WAIT);
  assign intSts = (state == ST_LEG_UP) || (state == ST_LEG_HOLD);

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    msiReq && !msiAck |=> msiReq); // R3

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    msiReq && msiAck |=> !msiReq); // R3

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rstN)
    !(msiReq && intSts)); // R9

  AST_LEG_UP_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LEG_UP) && !intAck |=> intSts); // R7

  AST_LEG_DOWN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LEG_DOWN) && !intAck |=> !intSts); // R8
endmodule

// File: rtl/msi_irq_requester.sv
module msi_irq_requester
  import irq_req_pkg::*;
#(
  parameter int NUM_VEC = 32,
  parameter int TC_W    = 3,
  parameter int MME_W   = 3,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_VEC-1:0] evtIn,
  input  logic               msiEn,
  input  logic [MME_W-1:0]   cfgMme,
  input  logic [TC_W-1:0]    cfgTc,
  output logic               msiReq,
  output logic [TC_W-1:0]    msiTc,
  output logic [VEC_W-1:0]   msiNum,
  input  logic               msiAck,
  output logic               intSts,
  input  logic               intAck
);
  dpCtl_t ctl;
  logic   anyPend;

  irq_req_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .msiEn   (msiEn),
    .anyPend (anyPend),
    .msiAck  (msiAck),
    .intAck  (intAck),
    .ctl     (ctl),
    .msiReq  (msiReq),
    .intSts  (intSts)
  );

  irq_req_datapath #(
    .NUM_VEC (NUM_VEC),
    .TC_W    (TC_W),
    .MME_W   (MME_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .evtIn   (evtIn),
    .ctl     (ctl),
    .cfgTc   (cfgTc),
    .cfgMme  (cfgMme),
    .anyPend (anyPend),
    .msiNum  (msiNum),
    .msiTc   (msiTc)
  );

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    msiReq && !msiAck |=> $stable(msiNum) && $stable(msiTc)); // R3
endmodule

// File: tb/msi_irq_requester_tb.sv
module msi_irq_requester_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] evtIn = '0;
  logic        msiEn = 1'b1;
  logic [2:0]  cfgMme = 3'd5;
  logic [2:0]  cfgTc = 3'd0;
  logic        msiReq;
  logic [2:0]  msiTc;
  logic [4:0]  msiNum;
  logic        msiAck = 1'b0;
  logic        intSts;
  logic        intAck = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  msi_irq_requester u_dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .msiEn(msiEn), .cfgMme(cfgMme),
    .cfgTc(cfgTc), .msiReq(msiReq), .msiTc(msiTc), .msiNum(msiNum),
    .msiAck(msiAck), .intSts(intSts), .intAck(intAck)
  );

  // {vector, mme, tc, expected num}
  localparam logic [15:0] VEC_TBL [10] = '{
    {5'd3,  3'd5, 3'd0, 5'd3},
    {5'd17, 3'd5, 3'd2, 5'd17},
    {5'd31, 3'd3, 3'd7, 5'd7},
    {5'd13, 3'd2, 3'd1, 5'd1},
    {5'd22, 3'd1, 3'd4, 5'd0},
    {5'd9,  3'd0, 3'd5, 5'd0},
    {5'd27, 3'd7, 3'd3, 5'd27},
    {5'd30, 3'd6, 3'd6, 5'd30},
    {5'd5,  3'd4, 3'd0, 5'd5},
    {5'd29, 3'd4, 3'd3, 5'd13}
  };

  task automatic check(input int act, input int exp, input string req);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulseEvt(input logic [31:0] bits);
    @(negedge clk) evtIn = bits;
    @(negedge clk) evtIn = '0;
  endtask

  task automatic ackMsi();
    @(negedge clk) msiAck = 1'b1;
    @(negedge clk) msiAck = 1'b0;
  endtask

  task automatic ackInt();
    @(negedge clk) intAck = 1'b1;
    @(negedge clk) intAck = 1'b0;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(msiReq, 0, "R1 msiReq in reset");
    check(intSts, 0, "R1 intSts in reset");
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(msiReq, 0, "R1 no request after reset");
    check(intSts, 0, "R1 no level after reset");
    check(msiNum, 0, "R1 msiNum after reset");

    // R2 R4 table walk
    for (int i = 0; i < 10; i++) begin
      cfgMme = VEC_TBL[i][7:5];
      cfgTc  = VEC_TBL[i][4:2] == 3'd0 ? VEC_TBL[i][4:2] : VEC_TBL[i][4:2];
      cfgTc  = VEC_TBL[i][7:5] == 3'd0 ? VEC_TBL[i][4:2] : VEC_TBL[i][4:2];
      cfgMme = VEC_TBL[i][10:8];
      cfgTc  = VEC_TBL[i][7:5];
      pulseEvt(32'd1 << VEC_TBL[i][15:11]);
      @(negedge clk);
      check(msiReq, 1, "R2 request raised");
      check(msiTc, int'(VEC_TBL[i][7:5]), "R2 traffic class");
      check(msiNum, int'(VEC_TBL[i][4:0]), "R4 folded vector");
      @(negedge clk);
      check(msiReq, 1, "R3 request held");
      ackMsi();
      check(msiReq, 0, "R3 dropped after ack");
    end

    // R3 stray ack is ignored
    cfgMme = 3'd5; cfgTc = 3'd2;
    ackMsi();
    check(msiReq, 0, "R3 stray ack no request");
    pulseEvt(32'd1 << 8);
    @(negedge clk);
    check(msiReq, 1, "R3 normal issue after stray ack");
    check(msiNum, 8, "R3 vector after stray ack");
    repeat (3) @(negedge clk);
    check(msiNum, 8, "R3 num stable while waiting");
    ackMsi();

    // R5 lowest first, one-cycle gap
    pulseEvt((32'd1 << 20) | (32'd1 << 4) | (32'd1 << 11));
    @(negedge clk);
    check(msiNum, 4, "R5 first lowest");
    ackMsi();
    check(msiReq, 0, "R5 gap cycle");
    @(negedge clk);
    check(msiReq, 1, "R5 second request");
    check(msiNum, 11, "R5 second lowest");
    ackMsi();
    @(negedge clk);
    check(msiNum, 20, "R5 third");
    ackMsi();

    // R6 event during outstanding request
    pulseEvt(32'd1 << 2);
    @(negedge clk);
    check(msiNum, 2, "R6 outstanding vector");
    pulseEvt(32'd1 << 1);
    check(msiNum, 2, "R6 current request unchanged");
    ackMsi();
    @(negedge clk);
    check(msiReq, 1, "R6 held event issued");
    check(msiNum, 1, "R6 held event vector");
    ackMsi();

    // R10 merge of repeated pulses
    pulseEvt(32'd1 << 7);
    @(negedge clk);
    pulseEvt(32'd1 << 6);
    pulseEvt(32'd1 << 6);
    ackMsi();
    @(negedge clk);
    check(msiNum, 6, "R10 merged vector");
    ackMsi();
    repeat (4) @(negedge clk);
    check(msiReq, 0, "R10 single request only");

    // R7 legacy raise, hold, release
    msiEn = 1'b0;
    pulseEvt(32'd1 << 3);
    @(negedge clk);
    check(intSts, 1, "R7 level raised");
    check(msiReq, 0, "R9 no msi in legacy");
    repeat (3) @(negedge clk);
    check(intSts, 1, "R7 level waits for ack");
    ackInt();
    check(intSts, 1, "R7 held after ack");
    @(negedge clk);
    check(intSts, 0, "R7 released when empty");

    // R8 fall needs confirmation before new raise
    pulseEvt(32'd1 << 5);
    repeat (2) @(negedge clk);
    check(intSts, 0, "R8 no raise before down ack");
    ackInt();
    check(intSts, 0, "R8 low at confirm");
    @(negedge clk);
    check(intSts, 1, "R8 raise after confirm");

    // R7 absorb events during hold
    @(negedge clk) begin intAck = 1'b1; evtIn = 32'd1 << 9; end
    @(negedge clk) begin intAck = 1'b0; evtIn = '0; end
    check(intSts, 1, "R7 held with new event");
    @(negedge clk);
    check(intSts, 1, "R7 absorbing event");
    @(negedge clk);
    check(intSts, 0, "R7 released after absorb");
    ackInt();
    repeat (3) @(negedge clk);
    check(intSts, 0, "R7 absorbed event not re-raised");

    // R9 mode change during an MSI request
    msiEn = 1'b1;
    pulseEvt(32'd1 << 12);
    @(negedge clk);
    msiEn = 1'b0;
    repeat (2) @(negedge clk);
    check(msiReq, 1, "R9 request survives mode change");
    check(intSts, 0, "R9 no level during request");
    ackMsi();
    repeat (2) @(negedge clk);
    check(intSts, 0, "R9 nothing left pending");
    check(msiReq, 0, "R9 request gone");

    finishRun();
  end
endmodule